// File: doc/BRIEF.md
# Double-buffered DAC input register

This block is a clocked front end for a 10-bit digital-to-analog converter. It sits on a processor write bus that is either 8 or 16 bits wide. A word passes through two registers in turn. The bus writes an input latch, and a DAC register holds the code that drives the converter.

A two-bit mode input chooses how the DAC register follows the latch:
- Flow-through: no holding.
- Single-buffered: one write updates the output.
- Double-buffered: an explicit transfer strobe moves the word.
- Automatic: the final write of a word also moves it.

On an 8-bit bus the word is left justified across two byte writes, and address bit 0 selects the byte. All strobes are active low and are sampled on the rising clock edge. An update pulse marks every change of the output code.

Top module: `dac_dbuf_front`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the input latch and the output code to 0 and drives `upd` low.
- R2: A write is accepted once, on the first clock edge at which `cs_n` and `wr_n` are both sampled low after a cycle in which they were not both low. Holding the strobes low makes no further writes, and `wr_n` low with `cs_n` high writes nothing.
- R3: With `bus16`=0 the bus is 8 bits wide. A write with `a0`=0 loads latch bits [9:2] from `din[7:0]`. A write with `a0`=1 loads latch bits [1:0] from `din[7:6]`, and `din[5:0]` is ignored.
- R4: With `bus16`=1 a single write loads all 10 latch bits from `din[15:6]`, whatever the value of `a0`.
- R5: In mode 0 (flow-through) the DAC register takes the latch's next value at every clock edge. A word written in this mode reaches `code` at the edge that samples the write. Entering mode 0 copies the current latch to `code` at the next edge.
- R6: In mode 1 (single-buffered) the edge that accepts a write also loads the new latch value into the DAC register. `xfer_n` has no effect.
- R7: In mode 2 (double-buffered) `code` holds while `xfer_n` is sampled high, even across latch writes. At each edge where `xfer_n` is sampled low, the DAC register takes the latch's next value.
- R8: In mode 3 (automatic) an 8-bit write with `a0`=0 never changes `code`. A write with `a0`=1, or any 16-bit write, completes the latch and loads the whole word into the DAC register at the same edge. `xfer_n` has no effect.
- R9: `upd` is high for exactly the one cycle following each clock edge at which `code` changed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Byte select on the 8-bit bus (0 = high byte, 1 = low bits) |
| xfer_n | input | 1 | Transfer strobe, active low, used in mode 2 |
| bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| mode | input | 2 | 0 flow-through, 1 single, 2 double, 3 automatic |
| din | input | 16 | Write data bus |
| code | output | 10 | DAC register contents, the converter code |
| upd | output | 1 | One-cycle pulse after each change of `code` |

## Verification
The embedded properties check every cycle that:
- `code` stays still when no write is pending outside flow-through and transfer;
- the double-buffered hold and the automatic-mode first byte leave `code` untouched;
- `upd` follows every change of `code` and nothing else;
- reset clears both outputs.

Only the bench's scenarios can show the following:
- that the bytes land in the right bit positions;
- that the ignored low bits of the second byte really are ignored;
- that a held strobe captures only its first data;
- that entering flow-through exposes a latched but untransferred word.

It sweeps all 1024 codes through the two-byte automatic path.

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              a0,
  input  logic              xfer_n,
  input  logic              bus16,
  input  logic [1:0]        mode,
  input  logic [15:0]       din,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  localparam int LO_W = CODE_W - 8;
  localparam logic [1:0] M_FLOW = 2'd0, M_SNGL = 2'd1, M_DBL = 2'd2, M_AUTO = 2'd3;

  logic              strobe_q;
  logic              wr_hit;
  logic              last_byte;
  logic [CODE_W-1:0] latch_q, latch_d, dac_d;

  assign wr_hit    = !cs_n && !wr_n && !strobe_q;
  assign last_byte = wr_hit && (bus16 || a0);

  always_comb begin
    latch_d = latch_q;
    if (wr_hit) begin
      if (bus16)   latch_d = din[15 -: CODE_W];
      else if (a0) latch_d[LO_W-1:0] = din[7 -: LO_W];
      else         latch_d[CODE_W-1 -: 8] = din[7:0];
    end
  end

  always_comb begin
    case (mode)
      M_FLOW:  dac_d = latch_d;
      M_SNGL:  dac_d = wr_hit ? latch_d : code;
      M_DBL:   dac_d = !xfer_n ? latch_d : code;
      default: dac_d = last_byte ? latch_d : code;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      latch_q  <= '0;
      code     <= '0;
      upd      <= 1'b0;
    end else begin
      strobe_q <= !cs_n && !wr_n;
      latch_q  <= latch_d;
      code     <= dac_d;
      upd      <= (dac_d != code);
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (code == '0 && !upd)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((cs_n || wr_n) && mode != M_FLOW && !(mode == M_DBL && !xfer_n)) |=> $stable(code)); // R2
  AST_DBL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == M_DBL && xfer_n) |=> $stable(code)); // R7
  AST_AUTO_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
    (mode == M_AUTO && !bus16 && !a0) |=> $stable(code)); // R8
  AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    upd |-> (code != $past(code))); // R9
  AST_CHANGE_MEANS_UPD: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> upd); // R9
endmodule

// File: tb/test_dac_dbuf_front.sv
module test_dac_dbuf_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, xfer_n = 1'b1, bus16 = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic [15:0] din = '0;
  logic [9:0]  code;
  logic        upd;
  int          checks = 0, errors = 0;
  logic [9:0]  code_after;
  logic        upd_after, upd_later;

  dac_dbuf_front i_dac_dbuf_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .a0(a0), .xfer_n(xfer_n),
    .bus16(bus16), .mode(mode), .din(din), .code(code), .upd(upd)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    cs_n = 1'b0; wr_n = 1'b0; a0 = sel; din = d;
    @(negedge clk);
    code_after = code; upd_after = upd;
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    upd_later = upd;
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] prev;
    repeat (3) @(negedge clk);
    check("R1 code", {6'b0, code}, 16'h0);
    check("R1 upd", {15'b0, upd}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R8 R9: full sweep through the automatic two-byte path on the 8-bit bus
    prev = '0;
    for (int v = 0; v < 1024; v++) begin
      logic [9:0] w;
      w = v[9:0];
      xfer_n = w[0];
      wr(1'b0, {8'hA5, w[9:2]});
      check("R8 first byte keeps code", {6'b0, code_after}, {6'b0, prev});
      check("R8 first byte no upd", {15'b0, upd_after}, 16'h0);
      wr(1'b1, {8'h5A, w[1:0], w[5:0] ^ 6'h2A});
      check("R3 second byte completes word", {6'b0, code_after}, {6'b0, w});
      check("R9 upd on change", {15'b0, upd_after}, {15'b0, w != prev});
      check("R9 upd one cycle", {15'b0, upd_later}, 16'h0);
      prev = w;
    end
    xfer_n = 1'b1;

    // R4: 16-bit bus, a0 ignored
    bus16 = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [9:0] w;
      w = 10'(v * 37 + 5);
      wr(v[0], {w, 6'(v ^ 21)});
      check("R4 16-bit write", {6'b0, code_after}, {6'b0, w});
    end

    // R6: single-buffered, xfer ignored
    mode = 2'd1;
    xfer_n = 1'b0;
    wr(1'b0, {10'h2C3, 6'h0});
    check("R6 single write", {6'b0, code_after}, 16'h2C3);
    xfer_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 xfer no effect", {6'b0, code}, 16'h2C3);

    // R2: held strobe captures once, deselected strobe ignored
    cs_n = 1'b0; wr_n = 1'b0; din = {10'h155, 6'h0};
    @(negedge clk);
    check("R2 first capture", {6'b0, code}, 16'h155);
    din = {10'h0AA, 6'h0};
    repeat (3) @(negedge clk);
    check("R2 held strobe no rewrite", {6'b0, code}, 16'h155);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 cs high ignored", {6'b0, code}, 16'h155);
    wr_n = 1'b1;
    @(negedge clk);

    // R7: double-buffered
    mode = 2'd2;
    wr(1'b0, {10'h3F0, 6'h0});
    check("R7 hold on write", {6'b0, code_after}, 16'h155);
    wr(1'b0, {10'h00F, 6'h0});
    check("R7 reload latch hold", {6'b0, code_after}, 16'h155);
    xfer_n = 1'b0;
    @(negedge clk);
    check("R7 transfer", {6'b0, code}, 16'h00F);
    check("R9 upd on transfer", {15'b0, upd}, 16'h1);
    xfer_n = 1'b1;
    @(negedge clk);
    check("R9 upd drops", {15'b0, upd}, 16'h0);
    check("R7 held after xfer", {6'b0, code}, 16'h00F);

    // R5: flow-through
    wr(1'b0, {10'h1E1, 6'h0});
    check("R7 untransferred", {6'b0, code_after}, 16'h00F);
    mode = 2'd0;
    @(negedge clk);
    check("R5 entering flow copies latch", {6'b0, code}, 16'h1E1);
    bus16 = 1'b0;
    wr(1'b0, 16'h0033);
    check("R5 flow byte visible", {6'b0, code_after}, {6'b0, 8'h33, 2'b01});

    // R1: reset from nonzero state
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset code", {6'b0, code}, 16'h0);
    check("R1 reset upd", {15'b0, upd}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule